// File: doc/BRIEF.md
# Fixed-Frequency PWM Channel Bank

This block turns an 8-bit period word and an 8-bit high-time word into a pulse-width-modulated waveform for each of `NCH` channels. A channel counts only on cycles where its count-enable strobe is high. The strobe is produced outside the block, either by a variable-rate divider or from the reference clock. One waveform cycle lasts `period + 1` strobes. The output is high for the first `high-time` strobes of that cycle.

New period and high-time values are taken into the counter only when a waveform cycle wraps, or at any time while the channel is stopped. A change made mid-cycle therefore never truncates a pulse.

Each channel has a four-bit control field. An output stage uses that field to turn the waveform into a pad data value and a pad drive-enable. The stage handles push-pull or open-drain drive, a force-high override, a tri-state disable, and a source select that can pass a raw variable-rate signal to the pad in place of the waveform. Register decode and strobe generation sit outside the block.

Top module: `pwmfx_top`

## Requirements
- R1: While reset is low, every channel counter and every latched period/high-time word returns to zero. Right after reset, a running channel with push-pull drive and tri-state disable low shows `pin_data=0` and `pin_oe=1` until its waveform starts.
- R2: With the fixed-frequency source selected and high-time ≤ period, the waveform is high for exactly `high-time` strobes out of every `period+1` strobes.
- R3: With the strobe held high on every clock, successive rising edges of the waveform are `period+1` clock cycles apart.
- R4: A high-time larger than the period gives a waveform that never goes low (for example high-time 0xFF with period 0xFE). A high-time of 0 gives a waveform that never goes high.
- R5: The counter advances only on clocks where the channel's strobe is high. A strobe on every other clock doubles the waveform period, and with no strobes the output does not change.
- R6: Period and high-time words written during a running cycle take effect only after that cycle completes, at the counter wrap.
- R7: Control field bit 0 (run) low holds the counter at zero and forces the waveform low. Raising it starts a cycle from count zero with the output high at once.
- R8: Control field bit 2 (force-high) drives the pad level high regardless of the waveform and of the run bit, provided bit 1 is low.
- R9: Control field bit 3 (open-drain) high turns a high level into `pin_oe=0`, and a low level into `pin_oe=1` with `pin_data=0`. With bit 3 low, `pin_oe=1` and `pin_data` equals the level.
- R10: Control field bit 1 (tri-state disable, active high) makes `pin_oe=0` and `pin_data=0` whatever the other bits are.
- R11: Select bit `src_sel[n]=1` routes the fixed-frequency waveform to the pad level. `src_sel[n]=0` routes `var_sig[n]` instead.
- R12: Channel n's control field is `ctrl[4n+3:4n]`. Each channel's pad outputs depend only on its own field, select, strobe, words and variable signal.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | NCH | Per-channel count-enable strobe |
| ctrl | input | 4*NCH | Per-channel control field: bit0 run, bit1 tri-state disable, bit2 force-high, bit3 open-drain |
| src_sel | input | NCH | 1 selects the fixed-frequency waveform, 0 selects the variable-rate signal |
| var_sig | input | NCH | Raw variable-rate signal per channel |
| period | input | 8*NCH | Period word per channel; the cycle length is period+1 strobes |
| high_time | input | 8*NCH | High-time word per channel, in strobes |
| pin_data | output | NCH | Pad data value |
| pin_oe | output | NCH | Pad drive-enable, active high |

## Verification
Some properties are checked on every clock by the assertions:
- the counter stays at or below its latched period;
- the counter is zero after a clock with the run bit low;
- the latched words stay stable between wraps;
- the pad outputs obey tri-state, open-drain and force-high.

Only the bench scenarios can show the following:
- the duty ratio and the spacing of rising edges for given words;
- the doubling of the period under a sparse strobe;
- the full-high and full-low extremes;
- the exact delay before words written mid-cycle take effect;
- the restart pulse length.

// File: rtl/pwmfx_pkg.sv
// Shared types and sizes for the fixed-frequency PWM bank.
// Assumes one 4-bit control field per channel; run sits at bit 0.
package pwmfx_pkg;
    localparam int CW_DEF   = 8;
    localparam int CTRL_W   = 4;

    // Control field; packed so that start is bit 0 and open_drain is bit 3.
    typedef struct packed {
        logic open_drain;
        logic force_high;
        logic oe_n;
        logic start;
    } ctrl_t;
endpackage

// File: rtl/pwmfx_counter.sv
// Period counter for one channel.
// Counts strobes from 0 to the latched period, then wraps. The period and
// high-time words are latched at the wrap or while stopped. The waveform is
// high while the count is below the latched high-time.
// Assumes period 0 is never used in operation (the counter then sits at 0).
module pwmfx_counter #(
    parameter int CW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          tick,
    input  logic [CW-1:0] period_i,
    input  logic [CW-1:0] on_i,
    output logic          wave_o
);
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] per_q;
    logic [CW-1:0] on_q;
    logic          wrap;

    assign wrap = tick && (cnt_q == per_q);

    // Count strobes, or hold at zero while stopped.
    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!start || wrap)
            cnt_q <= '0;
        else if (tick)
            cnt_q <= cnt_q + 1'b1;
    end

    // Latch new words only at a cycle boundary or when stopped.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            per_q <= '0;
            on_q  <= '0;
        end else if (!start || wrap) begin
            per_q <= period_i;
            on_q  <= on_i;
        end
    end

    // Waveform level; a high-time above the period yields 100 percent.
    assign wave_o = start && (cnt_q < on_q);

    assert_cnt_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= per_q);
    assert_hold_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> (cnt_q == '0));
    assert_shadow_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !wrap) |=> ($stable(per_q) && $stable(on_q)));
endmodule

// File: rtl/pwmfx_outstage.sv
// Pad output stage for one channel.
// Picks the level source (fixed waveform or raw variable signal), applies
// force-high, then maps the level to push-pull or open-drain drive. The
// tri-state disable overrides everything. Purely combinational.
module pwmfx_outstage
    import pwmfx_pkg::*;
(
    input  ctrl_t ctrl_i,
    input  logic  sel_fixed,
    input  logic  wave_i,
    input  logic  var_i,
    output logic  pin_data_o,
    output logic  pin_oe_o
);
    logic level;

    // Choose the source and apply force-high.
    always_comb begin
        level = ctrl_i.force_high ? 1'b1 : (sel_fixed ? wave_i : var_i);
    end

    // Map the level to pad drive.
    always_comb begin
        if (ctrl_i.oe_n) begin
            pin_data_o = 1'b0;
            pin_oe_o   = 1'b0;
        end else if (ctrl_i.open_drain) begin
            pin_data_o = 1'b0;
            pin_oe_o   = !level;
        end else begin
            pin_data_o = level;
            pin_oe_o   = 1'b1;
        end
    end
endmodule

// File: rtl/pwmfx_top.sv
// Bank of NCH fixed-frequency PWM channels, each with its own output stage.
// Assumes the strobes are synchronous to clk. Channel n uses control bits
// [4n+3:4n], word bits [CW*n+CW-1:CW*n] and bit n of the other vectors.
module pwmfx_top
    import pwmfx_pkg::*;
#(
    parameter int NCH = 2,
    parameter int CW  = CW_DEF
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NCH-1:0]      tick,
    input  logic [CTRL_W*NCH-1:0] ctrl,
    input  logic [NCH-1:0]      src_sel,
    input  logic [NCH-1:0]      var_sig,
    input  logic [CW*NCH-1:0]   period,
    input  logic [CW*NCH-1:0]   high_time,
    output logic [NCH-1:0]      pin_data,
    output logic [NCH-1:0]      pin_oe
);
    for (genvar ch = 0; ch < NCH; ch++) begin : g_ch
        ctrl_t f;
        logic  wave;

        assign f = ctrl_t'(ctrl[CTRL_W*ch +: CTRL_W]);

        pwmfx_counter #(.CW(CW)) u_cnt (
            .clk      (clk),
            .rst_n    (rst_n),
            .start    (f.start),
            .tick     (tick[ch]),
            .period_i (period[CW*ch +: CW]),
            .on_i     (high_time[CW*ch +: CW]),
            .wave_o   (wave)
        );

        pwmfx_outstage u_out (
            .ctrl_i     (f),
            .sel_fixed  (src_sel[ch]),
            .wave_i     (wave),
            .var_i      (var_sig[ch]),
            .pin_data_o (pin_data[ch]),
            .pin_oe_o   (pin_oe[ch])
        );

        assert_tristate_R10: assert property (@(posedge clk) disable iff (!rst_n)
            f.oe_n |-> (!pin_oe[ch] && !pin_data[ch]));
        assert_od_low_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
            (f.open_drain && pin_oe[ch]) |-> !pin_data[ch]);
        assert_force_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
            (f.force_high && !f.oe_n) |-> (f.open_drain ? !pin_oe[ch] : pin_data[ch]));
    end
endmodule

// File: tb/pwmfx_top_bench.sv
`timescale 1ns/1ps
module pwmfx_top_bench;
    localparam int NCH = 2;
    localparam int CW  = 8;

    logic             clk = 1'b0;
    logic             rst_n;
    logic [NCH-1:0]   tick;
    logic [4*NCH-1:0] ctrl;
    logic [NCH-1:0]   src_sel;
    logic [NCH-1:0]   var_sig;
    logic [CW*NCH-1:0] period;
    logic [CW*NCH-1:0] high_time;
    logic [NCH-1:0]   pin_data;
    logic [NCH-1:0]   pin_oe;

    int n_chk  = 0;
    int n_fail = 0;
    logic tick_div  = 1'b0;
    logic tick_hold = 1'b1;
    logic done = 1'b0;

    always #2 clk = ~clk;

    pwmfx_top #(.NCH(NCH), .CW(CW)) u_pwmfx_top (
        .clk(clk), .rst_n(rst_n), .tick(tick), .ctrl(ctrl),
        .src_sel(src_sel), .var_sig(var_sig), .period(period),
        .high_time(high_time), .pin_data(pin_data), .pin_oe(pin_oe)
    );

    // Channel 0 strobe: every clock, every other clock, or held.
    always @(negedge clk) begin
        if (tick_div) tick[0] <= ~tick[0];
        else          tick[0] <= tick_hold;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic set_ch0(input logic od, input logic fh, input logic oen, input logic run);
        ctrl[3:0] = {od, fh, oen, run};
    endtask

    task automatic count_high(input int n, output int hi);
        hi = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (pin_data[0]) hi++;
        end
    endtask

    // Length of the run at the current level, starting at the current sample.
    task automatic run_len(input logic lvl, output int n);
        n = 0;
        while (pin_data[0] == lvl && n < 1000) begin
            n++;
            @(negedge clk);
        end
    endtask

    task automatic wait_rise(output int n);
        logic prev;
        n = 0;
        prev = pin_data[0];
        @(negedge clk);
        while (!(pin_data[0] && !prev) && n < 2000) begin
            prev = pin_data[0];
            n++;
            @(negedge clk);
        end
        n++;
    endtask

    task automatic t_reset();
        @(negedge clk);
        check(pin_data[0] == 1'b0 && pin_oe[0] == 1'b1, "R1 idle data/oe", {pin_data[0], pin_oe[0]}, 1);
    endtask

    task automatic t_duty();
        int hi;
        period[7:0] = 8'd3; high_time[7:0] = 8'd1;
        set_ch0(0, 0, 0, 1);
        repeat (3) @(negedge clk);
        count_high(8, hi);
        check(hi == 2, "R2 duty 1/4", hi, 2);
        period[7:0] = 8'd9; high_time[7:0] = 8'd4;
        repeat (20) @(negedge clk);
        count_high(40, hi);
        check(hi == 16, "R2 duty 4/10", hi, 16);
    endtask

    task automatic t_period();
        int n;
        wait_rise(n);
        wait_rise(n);
        check(n == 10, "R3 rise spacing", n, 10);
    endtask

    task automatic t_full();
        int hi;
        period[7:0] = 8'hFE; high_time[7:0] = 8'hFF;
        repeat (300) @(negedge clk);
        count_high(50, hi);
        check(hi == 50, "R4 on>period full high", hi, 50);
        period[7:0] = 8'd5; high_time[7:0] = 8'd0;
        repeat (300) @(negedge clk);
        count_high(50, hi);
        check(hi == 0, "R4 on=0 full low", hi, 0);
    endtask

    task automatic t_tick();
        int n, hi;
        logic lvl;
        period[7:0] = 8'd3; high_time[7:0] = 8'd2;
        tick_div = 1'b1;
        repeat (20) @(negedge clk);
        wait_rise(n);
        wait_rise(n);
        check(n == 8, "R5 half-rate spacing", n, 8);
        tick_div = 1'b0; tick_hold = 1'b0;
        repeat (3) @(negedge clk);
        lvl = pin_data[0];
        count_high(20, hi);
        check(hi == (lvl ? 20 : 0), "R5 frozen without strobe", hi, lvl ? 20 : 0);
        tick_hold = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic t_shadow();
        int n;
        period[7:0] = 8'd7; high_time[7:0] = 8'd4;
        repeat (30) @(negedge clk);
        wait_rise(n);
        period[7:0] = 8'd1; high_time[7:0] = 8'd1;
        run_len(1'b1, n);
        check(n == 4, "R6 old high-time kept", n, 4);
        run_len(1'b0, n);
        check(n == 4, "R6 old period kept", n, 4);
        run_len(1'b1, n);
        check(n == 1, "R6 new high-time", n, 1);
        run_len(1'b0, n);
        check(n == 1, "R6 new period", n, 1);
    endtask

    task automatic t_start();
        int hi;
        set_ch0(0, 0, 0, 0);
        @(negedge clk);
        count_high(10, hi);
        check(hi == 0, "R7 stopped is low", hi, 0);
        period[7:0] = 8'd7; high_time[7:0] = 8'd3;
        @(negedge clk);
        set_ch0(0, 0, 0, 1);
        #1;
        run_len(1'b1, hi);
        check(hi == 3, "R7 restart pulse", hi, 3);
    endtask

    task automatic t_force();
        set_ch0(0, 1, 0, 0);
        @(negedge clk);
        check(pin_data[0] == 1'b1 && pin_oe[0] == 1'b1, "R8 force high", {pin_data[0], pin_oe[0]}, 3);
    endtask

    task automatic t_od();
        set_ch0(1, 1, 0, 0);
        @(negedge clk);
        check(pin_oe[0] == 1'b0, "R9 od high releases", pin_oe[0], 0);
        set_ch0(1, 0, 0, 0);
        @(negedge clk);
        check(pin_oe[0] == 1'b1 && pin_data[0] == 1'b0, "R9 od low drives 0", {pin_data[0], pin_oe[0]}, 1);
    endtask

    task automatic t_oen();
        set_ch0(0, 1, 1, 1);
        @(negedge clk);
        check(pin_oe[0] == 1'b0 && pin_data[0] == 1'b0, "R10 tri-state", {pin_data[0], pin_oe[0]}, 0);
    endtask

    task automatic t_sel();
        set_ch0(0, 0, 0, 1);
        src_sel[0] = 1'b0;
        var_sig[0] = 1'b1;
        @(negedge clk);
        check(pin_data[0] == 1'b1, "R11 var signal high", pin_data[0], 1);
        var_sig[0] = 1'b0;
        @(negedge clk);
        check(pin_data[0] == 1'b0, "R11 var signal low", pin_data[0], 0);
        src_sel[0] = 1'b1;
    endtask

    task automatic t_chan();
        set_ch0(0, 0, 0, 0);
        ctrl[7:4] = 4'b0100;
        @(negedge clk);
        check(pin_data == 2'b10 && pin_oe == 2'b11, "R12 channel fields", {pin_data, pin_oe}, 4'b1011);
    endtask

    initial begin
        rst_n = 1'b0;
        tick = '1;
        ctrl = 8'b0010_0000;
        src_sel = '1;
        var_sig = '0;
        period = '0;
        high_time = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_duty();
        t_period();
        t_full();
        t_tick();
        t_shadow();
        t_start();
        t_force();
        t_od();
        t_oen();
        t_sel();
        t_chan();
        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #400000;
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=0 expected=1");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule